// File: doc/BRIEF.md
# Power-Down Wake-Up Monitor

This block drives the serial data line of a small converter after the host has sent one of the two power-down codes. A decoder outside the block reports that the received code is a power-down code and which of the two it is. The block then counts host clock rising edges from the moment the session strobe falls and enters power-down on the fifth one. While in power-down it drives an idle level on the data line and watches every channel input that is both configured as digital and enabled for wake-up. When such an input differs from the level it had on entry, the block flips the data line and holds the flipped level until the host raises the session strobe.

Everything runs on a free-running sampling clock, so wake detection still works when the host stops its serial clock. The host clock and the strobe are treated as levels sampled on that clock.

Top module: `pd_wake_monitor`

## Requirements
- R1: After reset, `dio_oe`, `dio_out` and `pd_active` are all 0.
- R2: Power-down starts on the sampling clock edge that sees the fifth rising edge of `host_clk` after `start` went low, provided `pd_cmd` is 1 at that edge. With fewer edges, or with `pd_cmd` at 0, the block stays out of power-down.
- R3: With `pd_mode` = 0 latched on entry, `dio_out` idles at 0 and goes to 1 one sampling cycle after a wake event.
- R4: With `pd_mode` = 1 latched on entry, `dio_out` idles at 1 and goes to 0 one sampling cycle after a wake event.
- R5: Only channel i with `analog_mask[i]` = 0 (digital) and `wake_en[i]` = 1 can cause a wake event. Changes on other channels leave `dio_out` at its idle level.
- R6: Once the wake level is driven, it holds while `start` stays low, whatever the channel inputs do.
- R7: One sampling cycle after `start` is seen high, `dio_oe` and `pd_active` are 0 and `dio_out` is 0. A later power-down needs a new command and a new count of host clock edges.
- R8: Wake detection does not need `host_clk` activity. A wake event is seen with `host_clk` held still.
- R9: If `start` rises before any wake event, the block leaves power-down with the data line never having shown the wake level. Channel changes outside power-down have no effect on the outputs.
- R10: A wake event is a difference between a qualified channel and its level captured on the entry edge. A channel already high on entry does not count. A difference lasting one sampling cycle does count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host session strobe, low during a command |
| host_clk | input | 1 | Host serial clock level |
| pd_cmd | input | 1 | Decoded command is a power-down code |
| pd_mode | input | 1 | Which power-down code: 0 idles low, 1 idles high |
| analog_mask | input | N_CH | Per-channel analog attribute, 1 = analog |
| wake_en | input | N_CH | Per-channel wake-up enable, 1 = enabled |
| ch_in | input | N_CH | Channel logic levels |
| dio_out | output | 1 | Level driven on the data line |
| dio_oe | output | 1 | Data line driver enable |
| pd_active | output | 1 | Block is in power-down |

## Verification
Channel toggles are applied on an analog but enabled channel, on a digital but disabled channel and on a qualified channel. This tells the two mask bits apart from the true wake path. Both power-down codes are exercised: one with the host clock running and one with the host clock stopped, which separates the idle and flipped polarities and shows that detection does not depend on host edges. A one-cycle pulse, a channel that is high on entry and a second transition after wake-up show that detection compares against the entry snapshot and latches. Sessions with four host edges, with a non-power-down code and with an early strobe rise check the entry count and the quiet exit.

// File: rtl/pd_wake_monitor.sv
module pd_wake_monitor #(
  parameter int N_CH       = 8,
  parameter int ENTRY_EDGE = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            host_clk,
  input  logic            pd_cmd,
  input  logic            pd_mode,
  input  logic [N_CH-1:0] analog_mask,
  input  logic [N_CH-1:0] wake_en,
  input  logic [N_CH-1:0] ch_in,
  output logic            dio_out,
  output logic            dio_oe,
  output logic            pd_active
);
  localparam int CW = $clog2(ENTRY_EDGE + 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_WOKE} st_t;

  st_t             st;
  logic            hclk_q;
  logic            mode_q;
  logic [CW-1:0]   edges;
  logic [N_CH-1:0] base;

  wire             hclk_rise = host_clk & ~hclk_q;
  wire [N_CH-1:0]  watch     = wake_en & ~analog_mask;
  wire             hit       = |((ch_in ^ base) & watch);
  wire             arm       = (st == S_OFF) && hclk_rise && pd_cmd &&
                               (edges == CW'(ENTRY_EDGE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      hclk_q <= 1'b0;
      mode_q <= 1'b0;
      edges  <= '0;
      base   <= '0;
    end else begin
      hclk_q <= host_clk;
      if (start) begin
        st    <= S_OFF;
        edges <= '0;
      end else begin
        if (st == S_OFF && hclk_rise && edges != CW'(ENTRY_EDGE))
          edges <= edges + 1'b1;
        if (arm) begin
          st     <= S_WAIT;
          base   <= ch_in;
          mode_q <= pd_mode;
        end else if (st == S_WAIT && hit) begin
          st <= S_WOKE;
        end
      end
    end
  end

  assign dio_oe    = (st != S_OFF);
  assign pd_active = dio_oe;
  assign dio_out   = dio_oe & ((st == S_WOKE) ^ mode_q);
endmodule

// File: rtl/pd_wake_monitor_chk.sv
module pd_wake_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic pd_mode,
  input logic dio_out,
  input logic dio_oe
);
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dio_oe |-> !dio_out);

  assert_entry_in_session_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> !$past(start));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> (dio_out == pd_mode));

  assert_wake_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_oe && $past(dio_oe) && (dio_out != $past(dio_out))) |=> (!dio_oe || $stable(dio_out)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !dio_oe);
endmodule

bind pd_wake_monitor pd_wake_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pd_mode(pd_mode),
  .dio_out(dio_out), .dio_oe(dio_oe)
);

// File: tb/pd_wake_monitor_tb.sv
module pd_wake_monitor_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 1;
  logic       host_clk = 0;
  logic       pd_cmd = 0;
  logic       pd_mode = 0;
  logic [7:0] analog_mask = 8'h0F;
  logic [7:0] wake_en = 8'h35;
  logic [7:0] ch_in = 8'h10;
  logic       dio_out, dio_oe, pd_active;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";

  pd_wake_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .host_clk(host_clk),
    .pd_cmd(pd_cmd), .pd_mode(pd_mode), .analog_mask(analog_mask),
    .wake_en(wake_en), .ch_in(ch_in), .dio_out(dio_out), .dio_oe(dio_oe),
    .pd_active(pd_active)
  );

  always #5 clk = ~clk;

  // behavioural reference: 0 = out, 1 = waiting, 2 = woken
  int   m_phase = 0;
  int   m_edges = 0;
  logic m_prev = 0;
  logic m_mode = 0;
  logic [7:0] m_snap = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_edges = 0; m_prev = 0; m_mode = 0; m_snap = 0;
    end else begin
      if (start) begin
        m_phase = 0; m_edges = 0;
      end else if (m_phase == 0) begin
        if (host_clk && !m_prev) begin
          if (m_edges == 4 && pd_cmd) begin
            m_phase = 1; m_snap = ch_in; m_mode = pd_mode;
          end
          if (m_edges < 5) m_edges++;
        end
      end else if (m_phase == 1) begin
        for (int i = 0; i < 8; i++)
          if (ch_in[i] != m_snap[i] && wake_en[i] && !analog_mask[i]) m_phase = 2;
      end
      m_prev = host_clk;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      logic eo, ed;
      eo = (m_phase != 0);
      ed = eo && ((m_phase == 2) ^ m_mode);
      checks++;
      if (dio_oe !== eo || dio_out !== ed || pd_active !== eo) begin
        fails++;
        $display("FAIL %s cycle compare: actual oe=%b out=%b pd=%b expected oe=%b out=%b pd=%b",
                 cur_tag, dio_oe, dio_out, pd_active, eo, ed, eo);
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] got;
    got = {dio_oe, dio_out, pd_active};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s {oe,out,pd}: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hpulse();
    @(negedge clk) host_clk = 1;
    cyc(2);
    host_clk = 0;
    cyc(2);
  endtask

  task automatic enter(input logic mode, input logic cmd, input int n);
    @(negedge clk);
    start = 0; pd_cmd = cmd; pd_mode = mode;
    repeat (n) hpulse();
    cyc(2);
  endtask

  task automatic leave();
    @(negedge clk);
    start = 1; pd_cmd = 0;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    chk("R1", 3'b000);
    @(negedge clk) rst_n = 1;
    cyc(2);
    chk("R1", 3'b000);

    cur_tag = "R2";
    enter(1'b0, 1'b1, 4);
    chk("R2", 3'b000);
    hpulse();
    chk("R2", 3'b101);
    cur_tag = "R3";
    chk("R3", 3'b101);
    chk("R10", 3'b101);
    cur_tag = "R5";
    @(negedge clk) ch_in[0] = ~ch_in[0];
    cyc(3);
    chk("R5", 3'b101);
    @(negedge clk) ch_in[6] = ~ch_in[6];
    cyc(3);
    chk("R5", 3'b101);
    cur_tag = "R3";
    @(negedge clk) ch_in[5] = ~ch_in[5];
    cyc(2);
    chk("R3", 3'b111);
    cur_tag = "R6";
    @(negedge clk) begin ch_in[5] = ~ch_in[5]; ch_in[4] = ~ch_in[4]; end
    cyc(4);
    chk("R6", 3'b111);
    cur_tag = "R7";
    leave();
    chk("R7", 3'b000);

    cur_tag = "R8";
    ch_in = 8'h10;
    enter(1'b1, 1'b1, 5);
    chk("R4", 3'b111);
    cyc(20);
    chk("R8", 3'b111);
    @(negedge clk) ch_in[4] = 1'b0;
    cyc(2);
    chk("R4", 3'b101);
    chk("R8", 3'b101);
    cur_tag = "R7";
    leave();
    chk("R7", 3'b000);

    cur_tag = "R2";
    enter(1'b0, 1'b0, 6);
    chk("R2", 3'b000);
    leave();
    enter(1'b1, 1'b1, 4);
    leave();
    chk("R2", 3'b000);

    cur_tag = "R9";
    enter(1'b1, 1'b1, 5);
    chk("R9", 3'b111);
    leave();
    chk("R9", 3'b000);
    @(negedge clk) ch_in[5] = ~ch_in[5];
    cyc(3);
    chk("R9", 3'b000);

    cur_tag = "R10";
    enter(1'b0, 1'b1, 5);
    chk("R10", 3'b101);
    @(negedge clk) ch_in[5] = ~ch_in[5];
    @(negedge clk) ch_in[5] = ~ch_in[5];
    cyc(2);
    chk("R10", 3'b111);
    cur_tag = "R7";
    leave();
    chk("R7", 3'b000);

    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule